// File: doc/BRIEF.md
# Seven-segment display scan controller

The block drives a multi-digit seven-segment display in which each digit has a common-anode enable and all digits share one set of segment cathodes. It takes a 4-bit hexadecimal value, a decimal-point bit and a blank bit for every digit. It turns on the digits one at a time in a fixed repeating order. While a digit is enabled, the shared cathodes carry that digit's pattern. Because the whole display is cycled faster than the eye can follow, every digit appears to be lit all the time.

The scan rate is set by two parameters: the input clock frequency and the wanted full refresh period in microseconds. A period shorter than 1 ms or longer than 16 ms is refused when the design is elaborated, because a slow scan flickers visibly. Each digit slot begins with a single clock cycle in which every enable is off. During that cycle the block samples the inputs for the next digit. The new enable and its pattern then come up together, so a pattern is never shown on the wrong digit.

Top module: `seg_scan_ctrl`

## Requirements
- R1: While rst_ni is low, every digit enable, every segment line and the decimal-point line are inactive. After reset is released, the first digit lit is digit 0, on the first rising clock edge.
- R2: Digits are enabled in the order 0, 1, ..., NUM_DIGITS-1 and then start again at 0, endlessly. Digit i is an_o[i].
- R3: One digit slot lasts SLOT = (CLK_HZ/1000)*REFRESH_US/1000/NUM_DIGITS clock cycles. Within a slot, the digit is lit for SLOT-1 cycles. A REFRESH_US outside 1000..16000 fails elaboration.
- R4: At most one digit enable is active at any time. Between any two lit digits there is exactly one cycle with all enables inactive.
- R5: Values 0..9 produce the decimal patterns. The segment vector has seg_o[0]=a, seg_o[1]=b, and so on up to seg_o[6]=g. Written as active-high gfedcba, the patterns are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F.
- R6: Values 10..15 produce A, b, C, d, E, F. In active-high gfedcba these are 77, 7C, 39, 5E, 79, 71.
- R7: If blank_i[i] is set when digit i is sampled, all segments and the decimal point stay off during its slot, while its enable is still driven.
- R8: dp_o lights during digit i's slot exactly when dp_i[i] was set at sampling time.
- R9: The inputs are sampled once, at the rising edge that ends the all-off cycle of a slot. A change to any input during a slot has no effect on the outputs until a later slot samples it.
- R10: With the default parameters, an_o, seg_o and dp_o are active low, so a 0 means enabled or lit. AN_ACTIVE_LOW=0 or SEG_ACTIVE_LOW=0 makes the corresponding outputs active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digits_i | input | 4*NUM_DIGITS | Hex value of digit i in bits [4i+3:4i] |
| dp_i | input | NUM_DIGITS | Decimal-point request per digit |
| blank_i | input | NUM_DIGITS | Blank request per digit |
| an_o | output | NUM_DIGITS | Digit enables (common anodes) |
| seg_o | output | 7 | Shared segment cathodes, bit 0 = a ... bit 6 = g |
| dp_o | output | 1 | Shared decimal-point cathode |

## Verification
The hardest behaviour to provoke from the ports is the rule that inputs are sampled once per slot. A change must land strictly inside a lit slot, after the sampling edge and well before the next one. The stimulus therefore counts clock cycles from reset release and flips the digit value and the decimal-point bit halfway through chosen slots. It then expects the old pattern for the rest of that slot and the new value only when a later slot samples it. The gap between digits is checked by measuring the length of every lit window and every dark gap, not just the patterns.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int unsigned SEG_W          = 7;
  localparam int unsigned VAL_W          = 4;
  localparam int unsigned MIN_REFRESH_US = 1000;
  localparam int unsigned MAX_REFRESH_US = 16000;

  typedef logic [SEG_W-1:0] seg_t;  // active high, bit 0 = a .. bit 6 = g
endpackage

// File: rtl/seg_slot_timer.sv
module seg_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slot_start_o,
  output logic slot_last_o
);
  localparam int unsigned CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign slot_start_o = (cnt_q == '0);
  assign slot_last_o  = (cnt_q == CNT_W'(SLOT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (slot_last_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < SLOT_CYCLES);  // R3
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_last_o |=> slot_start_o);  // R3
endmodule

// File: rtl/seg_digit_ptr.sv
module seg_digit_ptr #(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned IDX_W     = $clog2(NUM_DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (advance_i) begin
      if (idx_q == IDX_W'(NUM_DIGITS - 1)) idx_q <= '0;
      else                                 idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < NUM_DIGITS);  // R2
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> (idx_q == (($past(idx_q) == IDX_W'(NUM_DIGITS - 1)) ? '0 : $past(idx_q) + 1'b1)));  // R2
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(idx_q));  // R2
endmodule

// File: rtl/seg_hex_decode.sv
module seg_hex_decode
  import seg_scan_pkg::*;
(
  input  logic [VAL_W-1:0] value_i,
  output seg_t             seg_o
);
  // gfedcba, active high
  always_comb begin
    unique case (value_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS     = 4,
  parameter int unsigned CLK_HZ         = 50_000_000,
  parameter int unsigned REFRESH_US     = 8000,
  parameter bit          AN_ACTIVE_LOW  = 1'b1,
  parameter bit          SEG_ACTIVE_LOW = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_DIGITS*VAL_W-1:0] digits_i,
  input  logic [NUM_DIGITS-1:0]       dp_i,
  input  logic [NUM_DIGITS-1:0]       blank_i,
  output logic [NUM_DIGITS-1:0]       an_o,
  output logic [SEG_W-1:0]            seg_o,
  output logic                        dp_o
);
  localparam int unsigned IDX_W          = $clog2(NUM_DIGITS);
  localparam int unsigned REFRESH_CYCLES = (CLK_HZ / 1000) * REFRESH_US / 1000;
  localparam int unsigned SLOT_CYCLES    = REFRESH_CYCLES / NUM_DIGITS;

  if (REFRESH_US < MIN_REFRESH_US || REFRESH_US > MAX_REFRESH_US || SLOT_CYCLES < 2
      || NUM_DIGITS < 2) begin : g_bad_cfg
    $error("seg_scan_ctrl: refresh period must be 1..16 ms with at least 2 cycles per slot");
  end

  logic             slot_start, slot_last;
  logic [IDX_W-1:0] idx;
  logic [VAL_W-1:0] cur_val;
  seg_t             cur_seg;
  logic [NUM_DIGITS-1:0] an_next;

  logic [NUM_DIGITS-1:0] an_q;
  seg_t                  seg_q;
  logic                  dp_q;

  seg_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_start_o (slot_start),
    .slot_last_o  (slot_last)
  );

  seg_digit_ptr #(.NUM_DIGITS(NUM_DIGITS)) i_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (slot_last),
    .idx_o     (idx)
  );

  assign cur_val = digits_i[{idx, 2'b00} +: VAL_W];

  seg_hex_decode i_dec (
    .value_i (cur_val),
    .seg_o   (cur_seg)
  );

  always_comb begin
    for (int i = 0; i < NUM_DIGITS; i++) an_next[i] = (IDX_W'(i) == idx);
  end

  // slot start: sample and light; slot end: all dark for the gap cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      an_q  <= '0;
      seg_q <= '0;
      dp_q  <= 1'b0;
    end else if (slot_start) begin
      an_q  <= an_next;
      seg_q <= blank_i[idx] ? '0 : cur_seg;
      dp_q  <= dp_i[idx] & ~blank_i[idx];
    end else if (slot_last) begin
      an_q  <= '0;
      seg_q <= '0;
      dp_q  <= 1'b0;
    end
  end

  if (AN_ACTIVE_LOW) begin : g_an_low
    assign an_o = ~an_q;
  end else begin : g_an_high
    assign an_o = an_q;
  end

  if (SEG_ACTIVE_LOW) begin : g_seg_low
    assign seg_o = ~seg_q;
    assign dp_o  = ~dp_q;
  end else begin : g_seg_high
    assign seg_o = seg_q;
    assign dp_o  = dp_q;
  end

  AST_ONE_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(an_q));  // R4
  AST_GAP_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_q != '0) |=> (an_q == '0) || $stable(an_q));  // R4
  AST_PATTERN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((an_q != '0) && $stable(an_q)) |-> ($stable(seg_q) && $stable(dp_q)));  // R9
  AST_LIT_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start |=> (an_q != '0));  // R3
  AST_DARK_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_last |=> (an_q == '0) && (seg_q == '0) && !dp_q);  // R4
endmodule

// File: tb/test_seg_scan_ctrl.sv
`timescale 1ns/1ps
module test_seg_scan_ctrl;
  localparam int N       = 4;
  localparam int CLK_HZ  = 40_000;
  localparam int REF_US  = 1000;
  localparam int S       = (CLK_HZ / 1000) * REF_US / 1000 / N;

  typedef struct {
    logic [N-1:0] an;
    logic [6:0]   seg;
    logic         dp;
    string        seg_tag;
    string        dp_tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [4*N-1:0] digits = '0;
  logic [N-1:0] dps = '0;
  logic [N-1:0] blanks = '0;
  logic [N-1:0] an_o;
  logic [6:0]   seg_o;
  logic         dp_o;

  int  n_vec = 0;
  int  n_err = 0;
  int  slot_no = 0;
  bit  stop = 1'b0;
  bit  done = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;

  seg_scan_ctrl #(.NUM_DIGITS(N), .CLK_HZ(CLK_HZ), .REFRESH_US(REF_US)) i_seg_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .digits_i(digits), .dp_i(dps), .blank_i(blanks),
    .an_o(an_o), .seg_o(seg_o), .dp_o(dp_o)
  );

  function automatic logic [6:0] hex_pat(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // driver: called at the negedge before a slot's sampling edge
  task automatic run_slot(input logic [4*N-1:0] d, input logic [N-1:0] p, input logic [N-1:0] b,
                          input bit glitch);
    item_t it;
    int k;
    logic [3:0] v;
    digits = d; dps = p; blanks = b;
    k = slot_no % N;
    v = d[4*k +: 4];
    it.an  = N'(1) << k;
    it.seg = b[k] ? 7'h00 : hex_pat(v);
    it.dp  = p[k] & ~b[k];
    it.seg_tag = b[k] ? "R7" : (glitch ? "R9" : ((v < 4'd10) ? "R5" : "R6"));
    it.dp_tag  = b[k] ? "R7" : (glitch ? "R9" : "R8");
    q.push_back(it);
    slot_no++;
    if (glitch) begin
      repeat (S / 2) @(negedge clk);
      digits = ~d; dps = ~p;
      repeat (S - S / 2) @(negedge clk);
    end else begin
      repeat (S) @(negedge clk);
    end
  endtask

  task automatic run_refresh(input logic [4*N-1:0] d, input logic [N-1:0] p, input logic [N-1:0] b,
                             input bit glitch);
    for (int i = 0; i < N; i++) run_slot(d, p, b, glitch && (i % 2 == 0));
  endtask

  // monitor
  initial begin
    logic [N-1:0] an_h, w_an;
    logic [6:0]   seg_h, w_seg;
    logic         dp_h, w_dp;
    bit in_win = 0, have_prev = 0;
    int len = 0, gap = 0;
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_ni && (!stop || in_win)) begin
        an_h = ~an_o; seg_h = ~seg_o; dp_h = ~dp_o;
        check($countones(an_h) <= 1, "R4", "enables active at once", $countones(an_h), 1);
        if (an_h != '0) begin
          if (!in_win) begin
            if (have_prev) check(gap == 1, "R4", "dark gap cycles", gap, 1);
            if (q.size() == 0) begin
              check(1'b0, "R2", "unexpected lit digit", an_h, 0);
            end else begin
              e = q.pop_front();
              check(an_h == e.an, "R2", "digit enable", an_h, e.an);
              check(seg_h == e.seg, e.seg_tag, "segments", seg_h, e.seg);
              check(dp_h == e.dp, e.dp_tag, "decimal point", dp_h, e.dp);
            end
            in_win = 1; w_an = an_h; w_seg = seg_h; w_dp = dp_h; len = 1;
          end else begin
            len++;
            check(an_h == w_an && seg_h == w_seg && dp_h == w_dp, "R9", "pattern changed in slot",
                  {an_h, seg_h, dp_h}, {w_an, w_seg, w_dp});
          end
          gap = 0;
        end else begin
          if (in_win) begin
            check(len == S - 1, "R3", "lit cycles per slot", len, S - 1);
            in_win = 0; have_prev = 1; gap = 1;
          end else begin
            gap++;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(an_o == '1, "R1", "enables in reset", an_o, 4'hF);
    check(seg_o == 7'h7F, "R10", "segments dark high in reset", seg_o, 7'h7F);
    check(dp_o == 1'b1, "R1", "dp in reset", dp_o, 1);
    rst_ni = 1'b1;
    run_refresh(16'h3271, 4'b0000, 4'b0000, 1'b0);           // R1 first digit 0, shows 1,7,2,3
    for (int r = 0; r < 4; r++)                              // R5 R6 all 16 values
      run_refresh({4'(4*r+3), 4'(4*r+2), 4'(4*r+1), 4'(4*r)}, 4'b0000, 4'b0000, 1'b0);
    run_refresh(16'h8888, 4'b0101, 4'b0000, 1'b0);           // R8
    run_refresh(16'h5A0E, 4'b1111, 4'b0010, 1'b0);           // R7
    run_refresh(16'h9C46, 4'b1010, 4'b0000, 1'b1);           // R9 mid-slot changes
    run_refresh(16'hB3D0, 4'b0001, 4'b1001, 1'b0);           // R7 R6 after glitch
    stop = 1'b1;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "scoreboard items left", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule